// File: doc/BRIEF.md
# Four-Road Rotating Signal Sequencer

This block drives the signal heads of a crossing where four roads of equal standing meet. Each road has a red, a yellow and a green lamp and a pedestrian walk lamp. The roads get right of way one at a time in a fixed rotation. Each road in turn gets a green interval and then a yellow interval. Its walk lamp is lit during that yellow interval. When the yellow interval ends, right of way passes to the next road and the first road goes back to red.

A single congestion sensor input sets the length of each interval. When it reads 0, the short green and yellow lengths apply. When it reads 1, the long lengths apply. The sensor is sampled only at the clock edge that starts an interval, and changes after that edge do not alter the interval that is running. All four interval lengths are parameters, counted in clock cycles. The reset is synchronous and active high. While reset is held, every road is red. At the first clock edge after release, north receives green.

Top module: `junction_sequencer`

## Requirements
- R1: While `rst` is sampled high, all four red lamps are on at the next cycle, and every yellow, green and walk lamp is off.
- R2: At the first rising edge with `rst` low after a reset, north (bit 0 of every lamp vector) turns green, and east, south and west (bits 1, 2 and 3) stay red.
- R3: Green is granted in the repeating order north, east, south, west. Each road's green follows the yellow of the road before it in that order, and north follows west.
- R4: During a green interval, the served road shows only green, the other three roads show only red, and no walk lamp is lit.
- R5: During a yellow interval, the served road shows only yellow and its own walk lamp is lit, while the other three roads show only red.
- R6: A green interval lasts GREEN_SHORT cycles when the sensor reads 0 at its starting edge, and GREEN_LONG cycles when it reads 1.
- R7: A yellow interval lasts YELLOW_SHORT cycles when the sensor reads 0 at its starting edge, and YELLOW_LONG cycles when it reads 1.
- R8: A change of the sensor after an interval's starting edge has no effect on that interval's length.
- R9: In every cycle, at most one road is not red, and each road has exactly one of its three lamps on.
- R10: A walk lamp is never lit unless the yellow lamp of the same road is lit.
- R11: Asserting reset in the middle of the rotation returns all roads to red. After release, the rotation restarts at north green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| heavy_traffic | input | 1 | Congestion sensor: 1 selects the long interval lengths |
| red_o | output | 4 | Red lamps, bit 0 north, 1 east, 2 south, 3 west |
| yellow_o | output | 4 | Yellow lamps, same bit order |
| green_o | output | 4 | Green lamps, same bit order |
| walk_o | output | 4 | Pedestrian walk lamps, same bit order |

## Verification
The properties assume that the sensor is a clean synchronous level and that reset is held for at least one edge before the rotation is judged. The order and start-up properties also rely on each interval lasting at least one cycle. The stimulus changes the sensor only between edges and holds it steady over long runs, so both the short and the long lengths are reached. It also toggles the sensor every few cycles so that it changes inside intervals that are already running. Reset is applied once at start-up and once in the middle of the rotation, and is released on a clean edge.

// File: rtl/js_pkg.sv
package js_pkg;
  localparam int ROADS = 4;

  typedef logic [1:0] road_t;

  typedef enum logic {
    PH_GO      = 1'b0,
    PH_CAUTION = 1'b1
  } phase_t;
endpackage

// File: rtl/js_phase_timer.sv
module js_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/js_sequencer.sv
module js_sequencer
  import js_pkg::*;
#(
  parameter int W            = 5,
  parameter int GREEN_SHORT  = 8,
  parameter int GREEN_LONG   = 16,
  parameter int YELLOW_SHORT = 3,
  parameter int YELLOW_LONG  = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         heavy,
  input  logic         expired,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         nxt_run,
  output road_t        nxt_road,
  output phase_t       nxt_phase
);
  localparam logic [W-1:0] GS_M1 = W'(GREEN_SHORT - 1);
  localparam logic [W-1:0] GL_M1 = W'(GREEN_LONG - 1);
  localparam logic [W-1:0] YS_M1 = W'(YELLOW_SHORT - 1);
  localparam logic [W-1:0] YL_M1 = W'(YELLOW_LONG - 1);

  logic   run_q;
  road_t  road_q;
  phase_t phase_q;
  logic [W-1:0] go_len, caution_len;

  assign go_len      = heavy ? GL_M1 : GS_M1;
  assign caution_len = heavy ? YL_M1 : YS_M1;

  always_comb begin
    nxt_run   = run_q;
    nxt_road  = road_q;
    nxt_phase = phase_q;
    load      = 1'b0;
    load_val  = '0;
    if (rst) begin
      nxt_run   = 1'b0;
      nxt_road  = '0;
      nxt_phase = PH_GO;
    end else if (!run_q) begin
      nxt_run   = 1'b1;
      nxt_road  = '0;
      nxt_phase = PH_GO;
      load      = 1'b1;
      load_val  = go_len;
    end else if (expired) begin
      load = 1'b1;
      if (phase_q == PH_GO) begin
        nxt_phase = PH_CAUTION;
        load_val  = caution_len;
      end else begin
        nxt_phase = PH_GO;
        nxt_road  = road_q + 2'd1;
        load_val  = go_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      road_q  <= '0;
      phase_q <= PH_GO;
    end else begin
      run_q   <= nxt_run;
      road_q  <= nxt_road;
      phase_q <= nxt_phase;
    end
  end
endmodule

// File: rtl/js_lamp_driver.sv
module js_lamp_driver
  import js_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_run,
  input  road_t            nxt_road,
  input  phase_t           nxt_phase,
  output logic [ROADS-1:0] red,
  output logic [ROADS-1:0] yel,
  output logic [ROADS-1:0] grn,
  output logic [ROADS-1:0] walk
);
  logic [ROADS-1:0] served;

  for (genvar i = 0; i < ROADS; i++) begin : g_sel
    assign served[i] = nxt_run && (nxt_road == road_t'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      red  <= '1;
      yel  <= '0;
      grn  <= '0;
      walk <= '0;
    end else begin
      red  <= ~served;
      grn  <= (nxt_phase == PH_GO)      ? served : '0;
      yel  <= (nxt_phase == PH_CAUTION) ? served : '0;
      walk <= (nxt_phase == PH_CAUTION) ? served : '0;
    end
  end
endmodule

// File: rtl/junction_sequencer.sv
module junction_sequencer
  import js_pkg::*;
#(
  parameter int GREEN_SHORT  = 8,
  parameter int GREEN_LONG   = 16,
  parameter int YELLOW_SHORT = 3,
  parameter int YELLOW_LONG  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       heavy_traffic,
  output logic [3:0] red_o,
  output logic [3:0] yellow_o,
  output logic [3:0] green_o,
  output logic [3:0] walk_o
);
  localparam int MAX_G = (GREEN_LONG > GREEN_SHORT) ? GREEN_LONG : GREEN_SHORT;
  localparam int MAX_Y = (YELLOW_LONG > YELLOW_SHORT) ? YELLOW_LONG : YELLOW_SHORT;
  localparam int MAX_D = (MAX_G > MAX_Y) ? MAX_G : MAX_Y;
  localparam int CW    = $clog2(MAX_D + 1);

  logic          load, expired, nxt_run;
  logic [CW-1:0] load_val;
  road_t         nxt_road;
  phase_t        nxt_phase;

  js_phase_timer #(.W(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  js_sequencer #(
    .W(CW), .GREEN_SHORT(GREEN_SHORT), .GREEN_LONG(GREEN_LONG),
    .YELLOW_SHORT(YELLOW_SHORT), .YELLOW_LONG(YELLOW_LONG)
  ) u_seq (
    .clk(clk), .rst(rst), .heavy(heavy_traffic), .expired(expired),
    .load(load), .load_val(load_val),
    .nxt_run(nxt_run), .nxt_road(nxt_road), .nxt_phase(nxt_phase)
  );

  js_lamp_driver u_lamps (
    .clk(clk), .rst(rst), .nxt_run(nxt_run), .nxt_road(nxt_road),
    .nxt_phase(nxt_phase),
    .red(red_o), .yel(yellow_o), .grn(green_o), .walk(walk_o)
  );
endmodule

// File: rtl/js_chk.sv
module js_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] red_o,
  input logic [3:0] yellow_o,
  input logic [3:0] green_o,
  input logic [3:0] walk_o
);
  // R1 and R11: a reset edge leaves every road red with no walk lamp
  a_r1_reset_red: assert property (@(posedge clk)
    rst |=> (red_o == 4'hF && yellow_o == 4'h0 && green_o == 4'h0 && walk_o == 4'h0));

  // R2: the first edge out of reset grants north
  a_r2_north_first: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rst) |=> (green_o == 4'b0001 && red_o == 4'b1110));

  // R9: at most one road away from red
  a_r9_one_road: assert property (@(posedge clk) disable iff (rst)
    $countones(~red_o) <= 1);

  // R10: walk only with the same road's yellow
  a_r10_walk_yellow: assert property (@(posedge clk) disable iff (rst)
    (walk_o & ~yellow_o) == 4'h0);

  for (genvar i = 0; i < 4; i++) begin : g_road
    // R9: exactly one lamp per road
    a_r9_one_lamp: assert property (@(posedge clk) disable iff (rst)
      $countones({red_o[i], yellow_o[i], green_o[i]}) == 1);

    // R5: yellow always comes with its walk lamp
    a_r5_walk_on: assert property (@(posedge clk) disable iff (rst)
      yellow_o[i] |-> walk_o[i]);

    // R3: a road's green follows the previous road's yellow (north may also follow all-red)
    if (i == 0) begin : g_first
      a_r3_order: assert property (@(posedge clk) disable iff (rst)
        $rose(green_o[0]) |-> ($past(yellow_o[3]) || $past(red_o == 4'hF)));
    end else begin : g_rest
      a_r3_order: assert property (@(posedge clk) disable iff (rst)
        $rose(green_o[i]) |-> $past(yellow_o[i-1]));
    end
  end
endmodule

bind junction_sequencer js_chk u_chk (
  .clk(clk), .rst(rst), .red_o(red_o), .yellow_o(yellow_o),
  .green_o(green_o), .walk_o(walk_o)
);

// File: tb/sim_junction_sequencer.sv
module sim_junction_sequencer;
  localparam int G_S = 8, G_L = 16, Y_S = 3, Y_L = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic heavy = 1'b0;
  logic [3:0] red_o, yellow_o, green_o, walk_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // reference model state
  int m_run = 0, m_road = 0, m_ph = 0, m_left = 0, m_len = 0;
  // output run-length monitor
  logic [15:0] prev_pat = 16'h0;
  int run_len = 0, prev_len = 0, prev_ph = 0, last_green = -1;
  bit prev_active = 1'b0;

  always #4 clk = ~clk;

  junction_sequencer #(
    .GREEN_SHORT(G_S), .GREEN_LONG(G_L), .YELLOW_SHORT(Y_S), .YELLOW_LONG(Y_L)
  ) u0 (
    .clk(clk), .rst(rst), .heavy_traffic(heavy),
    .red_o(red_o), .yellow_o(yellow_o), .green_o(green_o), .walk_o(walk_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic model_step(input bit r, input bit h);
    if (r) begin
      m_run = 0;
    end else if (m_run == 0) begin
      m_run = 1; m_road = 0; m_ph = 0;
      m_len = h ? G_L : G_S; m_left = m_len;
    end else begin
      m_left--;
      if (m_left == 0) begin
        if (m_ph == 0) begin
          m_ph = 1; m_len = h ? Y_L : Y_S;
        end else begin
          m_ph = 0; m_road = (m_road + 1) % 4; m_len = h ? G_L : G_S;
        end
        m_left = m_len;
      end
    end
  endtask

  task automatic cyc(input bit nr, input bit nh);
    logic [3:0] er, ey, eg, ew;
    logic [15:0] pat, epat;
    bit edge_rst;
    int nonred, g;
    @(negedge clk);
    edge_rst = rst;
    model_step(rst, heavy);
    er = 4'hF; ey = 4'h0; eg = 4'h0; ew = 4'h0;
    if (m_run != 0) begin
      er[m_road] = 1'b0;
      if (m_ph == 0) eg[m_road] = 1'b1;
      else begin ey[m_road] = 1'b1; ew[m_road] = 1'b1; end
    end
    pat  = {red_o, yellow_o, green_o, walk_o};
    epat = {er, ey, eg, ew};
    if (m_run == 0)   check(pat == epat, "R1 R11 all-red", pat, epat);
    else if (m_ph == 0) check(pat == epat, "R4 green pattern", pat, epat);
    else              check(pat == epat, "R5 yellow pattern", pat, epat);

    nonred = 0;
    for (int i = 0; i < 4; i++) begin
      if (!red_o[i]) nonred++;
      check((int'(red_o[i]) + int'(yellow_o[i]) + int'(green_o[i])) == 1,
            "R9 one lamp per road", {red_o[i], yellow_o[i], green_o[i]}, 1);
    end
    check(nonred <= 1, "R9 single road moving", nonred, 1);
    check((walk_o & ~yellow_o) == 4'h0, "R10 walk outside yellow", walk_o, yellow_o & walk_o);

    if (edge_rst) last_green = -1;
    if (pat != prev_pat) begin
      if (prev_active && !edge_rst) begin
        if (prev_ph == 0) check(run_len == prev_len, "R6 R8 green length", run_len, prev_len);
        else              check(run_len == prev_len, "R7 R8 yellow length", run_len, prev_len);
      end
      if (green_o != 4'h0) begin
        g = 0;
        for (int i = 0; i < 4; i++) if (green_o[i]) g = i;
        if (last_green < 0) check(g == 0, "R2 north first", g, 0);
        else                check(g == (last_green + 1) % 4, "R3 rotation order", g, (last_green + 1) % 4);
        last_green = g;
      end
      run_len = 1;
    end else begin
      run_len++;
    end
    prev_pat = pat;
    prev_active = (m_run != 0);
    prev_len = m_len;
    prev_ph = m_ph;

    rst = nr;
    heavy = nh;
  endtask

  initial begin
    repeat (3) cyc(1'b1, 1'b0);
    repeat (70) cyc(1'b0, 1'b0);
    repeat (90) cyc(1'b0, 1'b1);
    for (int i = 0; i < 120; i++) cyc(1'b0, ((i / 3) % 2) == 1);
    repeat (2) cyc(1'b1, 1'b1);
    for (int i = 0; i < 160; i++) cyc(1'b0, ((i / 7) % 2) == 1);
    repeat (5) cyc(1'b0, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 20000, 0);
      summary();
      $finish;
    end
  end
endmodule